// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. Once reset is released it holds the memory pins quiet for a long settle interval. It then asks the access sequencer for the bus and issues a fixed number of dummy RAS cycles back to back. Only after the last of those cycles has finished its precharge does it raise `ready`. From then on an interval timer makes a refresh due at a fixed rate, chosen so that every row is refreshed once per refresh period.

Each refresh is either a RAS-only cycle or a CAS-before-RAS cycle. A RAS-only cycle puts an internal row counter on the address pins, and that counter then advances. A CAS-before-RAS cycle lets the DRAM count rows internally. The `mode_cbr` input picks the kind of cycle at the start of each one. The block shares the pins with the access sequencer through `req`/`gnt`. Refreshes that fall due while the grant is withheld are counted up to a limit and then issued as one burst. If RAS stays inactive for too long, the block drops `ready` and runs the dummy cycles again, without the settle pause.

The control is one state machine with these states:
- ST_PAUSE: settle interval after reset.
- ST_INIT_REQ: waiting for a grant before the dummy cycles.
- ST_IDLE: nothing due.
- ST_REF_REQ: a refresh is due and the block is waiting for a grant.
- ST_CBR_CAS: CAS is low while RAS is still high.
- ST_RAS_ACT: RAS is low.
- ST_PRECHG: RAS is high again (precharge).

The transitions are:
- pause_done: ST_PAUSE to ST_INIT_REQ.
- grant_start: a grant moves ST_INIT_REQ or ST_REF_REQ to ST_CBR_CAS or ST_RAS_ACT.
- cas_lead: ST_CBR_CAS to ST_RAS_ACT.
- ras_done: ST_RAS_ACT to ST_PRECHG.
- chain: ST_PRECHG to the next cycle's first state.
- init_done: ST_PRECHG to ST_IDLE with `ready` raised.
- burst_done: ST_PRECHG to ST_IDLE.
- due: ST_IDLE to ST_REF_REQ.
- stale: ST_IDLE or ST_REF_REQ to ST_INIT_REQ with `ready` dropped.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `ready`, `req` and `drive` are 0 and `ras_n` and `cas_n` are 1.
- R2: After reset is released, `req` stays 0 and `ras_n` stays 1 for exactly PAUSE_CYC clock cycles. `req` is 1 in the cycle after that.
- R3: After the first grant, exactly INIT_N RAS cycles are issued back to back. Each cycle holds `ras_n` low for RAS_CYC cycles and then high for at least RP_CYC cycles. No access cycle is used for this.
- R4: `ready` is 0 through the pause and all dummy cycles. It rises exactly RP_CYC cycles after `ras_n` rises for the last time in the dummy sequence.
- R5: In CAS-before-RAS mode (`mode_cbr`=1), `cas_n` falls one cycle before `ras_n`, while `ras_n` is still high. `cas_n` stays low while `ras_n` is low and rises together with `ras_n`. The row counter does not change.
- R6: In RAS-only mode (`mode_cbr`=0), `cas_n` stays 1 and `addr` carries the row counter. The counter advances by one after each cycle and wraps from ROWS-1 to 0.
- R7: Once `ready` is 1, a refresh falls due every REF_PERIOD_CYC/ROWS cycles. With the grant held, successive refresh RAS falls are exactly that many cycles apart.
- R8: A due refresh keeps `req` at 1 without driving the pins until `gnt` arrives. The refreshes that fell due are counted, saturating at MAX_PEND. On the grant they are issued back to back, and `req` falls only after the last one.
- R9: The block counts cycles spent waiting (idle or awaiting grant) while `ext_ras_act` is 0. After IDLE_CYC such consecutive cycles, `ready` falls and `req` rises. The next grant then starts INIT_N dummy cycles one cycle later, with no pause. Any pulse on `ext_ras_act` restarts the count.
- R10: `drive` is 1 exactly while the block owns the pins. It rises only after a grant. `ras_n` and `cas_n` are never low while `drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_cbr | input | 1 | 1 selects CAS-before-RAS refresh, 0 selects RAS-only refresh |
| gnt | input | 1 | Pin grant from the access sequencer |
| ext_ras_act | input | 1 | Pulses when the access sequencer drives RAS low |
| req | output | 1 | Pin request to the access sequencer |
| drive | output | 1 | The block owns RAS, CAS and address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr | output | $clog2(ROWS) | Row address for RAS-only cycles |
| ready | output | 1 | DRAM is initialized and usable |

## Verification
The grant is tried in two ways: held permanently, and withheld for a random number of refresh intervals. Holding it isolates the refresh rate and the exact pulse shapes. Withholding it separates the pending count from its saturation limit, because short waits must produce exactly one more pulse than the intervals missed, while long waits must stop at the limit. Both refresh modes are run over the same intervals. This shows that only RAS-only cycles move the address and only CAS-before-RAS cycles lead with CAS. Periodic `ext_ras_act` pulses against a long quiet gap show whether the inactivity count restarts on outside activity or only on the block's own cycles.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_INIT_REQ,
        ST_IDLE,
        ST_REF_REQ,
        ST_CBR_CAS,
        ST_RAS_ACT,
        ST_PRECHG
    } dref_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dref_tick.sv
// Interval timer: one-cycle pulse every PERIOD cycles while enabled.
module dref_tick #(
    parameter int PERIOD = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(PERIOD - 1));
    assign tick = en && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!en)    cnt_q <= '0;
        else if (wrap)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dref_pend.sv
// Saturating count of refreshes that fell due but were not yet issued.
module dref_pend #(
    parameter int MAXP = 8,
    localparam int PW  = $clog2(MAXP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          dec,
    output logic [PW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt != PW'(MAXP)) cnt <= cnt + 1'b1;
                2'b01:   if (cnt != '0)        cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/dref_row.sv
// Row counter for RAS-only refresh, wrapping at ROWS.
module dref_row #(
    parameter int ROWS  = 4096,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [RW-1:0] row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     row <= '0;
        else if (step)  row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dref_pkg::*;
#(
    parameter int PAUSE_CYC      = 25000,
    parameter int REF_PERIOD_CYC = 3200000,
    parameter int ROWS           = 4096,
    parameter int INIT_N         = 8,
    parameter int RAS_CYC        = 3,
    parameter int RP_CYC         = 2,
    parameter int MAX_PEND       = 8,
    parameter int IDLE_CYC       = 3200000,
    localparam int ROW_W         = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_cbr,
    input  logic             gnt,
    input  logic             ext_ras_act,
    output logic             req,
    output logic             drive,
    output logic             ras_n,
    output logic             cas_n,
    output logic [ROW_W-1:0] addr,
    output logic             ready
);
    localparam int REFI_CYC = REF_PERIOD_CYC / ROWS;
    localparam int SEQ_MAX  = max3(PAUSE_CYC, RAS_CYC, RP_CYC);
    localparam int SEQ_W    = $clog2(SEQ_MAX + 1);
    localparam int INIT_W   = $clog2(INIT_N + 1);
    localparam int IDLE_W   = $clog2(IDLE_CYC + 1);
    localparam int PEND_W   = $clog2(MAX_PEND + 1);

    dref_state_e        state_q, state_d;
    logic [SEQ_W-1:0]   seq_q, seq_d;
    logic [INIT_W-1:0]  init_q, init_d;
    logic               in_init_q, in_init_d;
    logic               cbr_q, cbr_d;
    logic               rdy_q, rdy_d;
    logic [IDLE_W-1:0]  idle_q;

    logic               tick, pend_dec, pend_clr, row_step;
    logic [PEND_W-1:0]  pend_cnt;
    logic [ROW_W-1:0]   row;
    logic               waiting, idle_hit;
    dref_state_e        first_st;

    dref_tick #(.PERIOD(REFI_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(rdy_q), .tick(tick)
    );

    dref_pend #(.MAXP(MAX_PEND)) u_pend (
        .clk(clk), .rst_n(rst_n), .clr(pend_clr),
        .inc(tick), .dec(pend_dec), .cnt(pend_cnt)
    );

    dref_row #(.ROWS(ROWS)) u_row (
        .clk(clk), .rst_n(rst_n), .step(row_step), .row(row)
    );

    // RAS inactivity: consecutive waiting cycles with no outside RAS activity
    assign waiting  = (state_q == ST_IDLE) || (state_q == ST_REF_REQ);
    assign idle_hit = waiting && !ext_ras_act && (idle_q == IDLE_W'(IDLE_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         idle_q <= '0;
        else if (waiting && !ext_ras_act)   idle_q <= idle_hit ? '0 : idle_q + 1'b1;
        else                                idle_q <= '0;
    end

    assign first_st = mode_cbr ? ST_CBR_CAS : ST_RAS_ACT;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_PAUSE;
            seq_q     <= '0;
            init_q    <= '0;
            in_init_q <= 1'b1;
            cbr_q     <= 1'b0;
            rdy_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            seq_q     <= seq_d;
            init_q    <= init_d;
            in_init_q <= in_init_d;
            cbr_q     <= cbr_d;
            rdy_q     <= rdy_d;
        end
    end

    // Next state
    always_comb begin
        state_d   = state_q;
        seq_d     = seq_q;
        init_d    = init_q;
        in_init_d = in_init_q;
        cbr_d     = cbr_q;
        rdy_d     = rdy_q;
        pend_dec  = 1'b0;
        pend_clr  = 1'b0;
        row_step  = 1'b0;
        unique case (state_q)
            ST_PAUSE: begin
                if (seq_q == SEQ_W'(PAUSE_CYC - 1)) begin      // pause_done
                    state_d = ST_INIT_REQ;
                    seq_d   = '0;
                end else begin
                    seq_d   = seq_q + 1'b1;
                end
            end
            ST_INIT_REQ: begin
                if (gnt) begin                                  // grant_start
                    state_d = first_st;
                    cbr_d   = mode_cbr;
                    seq_d   = '0;
                end
            end
            ST_IDLE: begin
                if (idle_hit) begin                             // stale
                    state_d   = ST_INIT_REQ;
                    rdy_d     = 1'b0;
                    in_init_d = 1'b1;
                    init_d    = '0;
                    pend_clr  = 1'b1;
                end else if (pend_cnt != '0) begin              // due
                    state_d   = ST_REF_REQ;
                end
            end
            ST_REF_REQ: begin
                if (idle_hit) begin                             // stale
                    state_d   = ST_INIT_REQ;
                    rdy_d     = 1'b0;
                    in_init_d = 1'b1;
                    init_d    = '0;
                    pend_clr  = 1'b1;
                end else if (gnt) begin                         // grant_start
                    state_d = first_st;
                    cbr_d   = mode_cbr;
                    seq_d   = '0;
                end
            end
            ST_CBR_CAS: begin                                   // cas_lead
                state_d = ST_RAS_ACT;
                seq_d   = '0;
            end
            ST_RAS_ACT: begin
                if (seq_q == SEQ_W'(RAS_CYC - 1)) begin         // ras_done
                    state_d  = ST_PRECHG;
                    seq_d    = '0;
                    row_step = !cbr_q;
                end else begin
                    seq_d    = seq_q + 1'b1;
                end
            end
            ST_PRECHG: begin
                if (seq_q == SEQ_W'(RP_CYC - 1)) begin
                    seq_d = '0;
                    if (in_init_q) begin
                        if (init_q == INIT_W'(INIT_N - 1)) begin    // init_done
                            state_d   = ST_IDLE;
                            rdy_d     = 1'b1;
                            in_init_d = 1'b0;
                            init_d    = '0;
                        end else begin                              // chain
                            init_d  = init_q + 1'b1;
                            state_d = first_st;
                            cbr_d   = mode_cbr;
                        end
                    end else begin
                        pend_dec = 1'b1;
                        if ((pend_cnt > PEND_W'(1)) || tick) begin  // chain
                            state_d = first_st;
                            cbr_d   = mode_cbr;
                        end else begin                              // burst_done
                            state_d = ST_IDLE;
                        end
                    end
                end else begin
                    seq_d = seq_q + 1'b1;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        req   = 1'b0;
        drive = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        unique case (state_q)
            ST_PAUSE, ST_IDLE: begin
            end
            ST_INIT_REQ, ST_REF_REQ: begin
                req = 1'b1;
            end
            ST_CBR_CAS: begin
                req   = 1'b1;
                drive = 1'b1;
                cas_n = 1'b0;
            end
            ST_RAS_ACT: begin
                req   = 1'b1;
                drive = 1'b1;
                ras_n = 1'b0;
                cas_n = !cbr_q;
            end
            ST_PRECHG: begin
                req   = 1'b1;
                drive = 1'b1;
            end
        endcase
    end

    assign addr  = row;
    assign ready = rdy_q;

endmodule

// File: rtl/dref_checker.sv
module dref_checker #(
    parameter int RP_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic gnt,
    input logic req,
    input logic drive,
    input logic ras_n,
    input logic cas_n,
    input logic ready
);
    logic [7:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              hi_q <= '0;
        else if (!ras_n)         hi_q <= '0;
        else if (hi_q != 8'hFF)  hi_q <= hi_q + 1'b1;
    end

    AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (int'(hi_q) >= RP_CYC)); // R3

    AST_READY_AFTER_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(ras_n) && $past(drive))); // R4

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> ($past(!cas_n) && $past(ras_n))); // R5

    AST_CAS_RISES_WITH_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> $rose(ras_n)); // R5

    AST_REQ_HELD_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(drive)); // R8

    AST_STALE_REINIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> (req && !drive)); // R9

    AST_PINS_ONLY_WHEN_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |-> (ras_n && cas_n)); // R10

    AST_DRIVE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> $past(gnt)); // R10

endmodule

bind dram_refresh_sched dref_checker #(.RP_CYC(RP_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .gnt(gnt), .req(req), .drive(drive),
    .ras_n(ras_n), .cas_n(cas_n), .ready(ready)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
    localparam int PAUSE = 20;
    localparam int ROWS  = 16;
    localparam int PER   = 640;
    localparam int REFI  = PER / ROWS;
    localparam int INITN = 8;
    localparam int RASC  = 3;
    localparam int RPC   = 2;
    localparam int MAXP  = 4;
    localparam int IDLE  = 300;

    logic clk = 1'b0, rst_n = 1'b0, mode_cbr = 1'b0, gnt = 1'b0, ext = 1'b0;
    logic req, drive, ras_n, cas_n, ready;
    logic [3:0] addr;

    dram_refresh_sched #(
        .PAUSE_CYC(PAUSE), .REF_PERIOD_CYC(PER), .ROWS(ROWS), .INIT_N(INITN),
        .RAS_CYC(RASC), .RP_CYC(RPC), .MAX_PEND(MAXP), .IDLE_CYC(IDLE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_cbr(mode_cbr), .gnt(gnt),
        .ext_ras_act(ext), .req(req), .drive(drive), .ras_n(ras_n),
        .cas_n(cas_n), .addr(addr), .ready(ready)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0, exp_row = 0;
    int b_pulses, b_len_bad, b_gap_bad, b_addr_bad, b_cas_bad, b_drv_bad, b_rdy_early, b_tail, b_first;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int exp_burst(input int m);
        return (1 + m > MAXP) ? MAXP : 1 + m;
    endfunction

    task automatic wait_req();
        for (int i = 0; i < 2000; i++) begin
            if (req) break;
            @(negedge clk);
        end
    endtask

    // Observe one owned period until req falls
    task automatic burst(input bit cbr, input bit init_phase);
        logic pr, pc;
        int low, hi;
        b_pulses = 0; b_len_bad = 0; b_gap_bad = 0; b_addr_bad = 0;
        b_cas_bad = 0; b_drv_bad = 0; b_rdy_early = 0; b_first = -1;
        pr = ras_n; pc = cas_n; low = 0; hi = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if ((!ras_n || !cas_n) && !drive) b_drv_bad++;
            if (init_phase && req && ready) b_rdy_early++;
            if (!ras_n) begin
                if (pr) begin
                    b_pulses++;
                    if (b_first < 0) b_first = cyc;
                    if (b_pulses > 1 && hi != (cbr ? RPC + 1 : RPC)) b_gap_bad++;
                    if (addr != 4'(exp_row)) b_addr_bad++;
                    if (cbr) begin
                        if (pc) b_cas_bad++;
                    end else begin
                        exp_row = (exp_row + 1) % ROWS;
                    end
                end
                if (cas_n == cbr) b_cas_bad++;
                low++; hi = 0;
            end else begin
                if (!pr && low != RASC) b_len_bad++;
                low = 0; hi++;
            end
            pr = ras_n; pc = cas_n;
            if (!req) break;
        end
        b_tail = hi - 1;
    endtask

    initial begin
        int n, t_prev, m, wrap_seen;
        void'($urandom(32'd4242));

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!ready && !req && !drive && ras_n && cas_n, "R1 reset outputs",
            {ready, req, drive, ras_n, cas_n}, 5'b00011);

        // R2 pause length
        rst_n = 1'b1;
        n = 0; m = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            n++;
            if (!ras_n || ready) m++;
            if (req) break;
        end
        chk(n == PAUSE, "R2 pause cycles", n, PAUSE);
        chk(m == 0, "R2 pins quiet in pause", m, 0);

        // R3/R4/R6 initialization in RAS-only mode
        gnt = 1'b1;
        burst(1'b0, 1'b1);
        chk(b_pulses == INITN, "R3 dummy cycle count", b_pulses, INITN);
        chk(b_len_bad == 0, "R3 RAS low width", b_len_bad, 0);
        chk(b_gap_bad == 0, "R3 precharge between cycles", b_gap_bad, 0);
        chk(b_rdy_early == 0, "R4 ready low during init", b_rdy_early, 0);
        chk(ready == 1'b1, "R4 ready after init", ready, 1);
        chk(b_tail == RPC, "R4 ready delay after last RAS rise", b_tail, RPC);
        chk(b_addr_bad == 0 && b_cas_bad == 0, "R6 init rows and CAS high", b_addr_bad + b_cas_bad, 0);
        chk(b_drv_bad == 0, "R10 drive during init", b_drv_bad, 0);

        // R7 refresh spacing, R6 wrap, grant held
        t_prev = -1; m = 0; n = 0; wrap_seen = 0;
        for (int k = 0; k < 10; k++) begin
            wait_req();
            if (exp_row == ROWS - 1) wrap_seen = 1;
            burst(1'b0, 1'b0);
            if (b_pulses != 1) n++;
            if (t_prev >= 0 && b_first - t_prev != REFI) m++;
            t_prev = b_first;
            if (b_addr_bad != 0 || b_cas_bad != 0 || b_drv_bad != 0) n++;
        end
        chk(m == 0, "R7 refresh interval", m, 0);
        chk(n == 0, "R6 RAS-only rows, one pulse each", n, 0);
        chk(wrap_seen == 1 && exp_row == 2, "R6 row wrap", exp_row, 2);

        // R5 CAS-before-RAS keeps row
        mode_cbr = 1'b1;
        n = 0;
        for (int k = 0; k < 3; k++) begin
            wait_req();
            burst(1'b1, 1'b0);
            if (b_pulses != 1 || b_cas_bad != 0 || b_addr_bad != 0 || b_drv_bad != 0) n++;
        end
        chk(n == 0, "R5 CAS leads RAS, row unchanged", n, 0);
        mode_cbr = 1'b0;
        wait_req();
        burst(1'b0, 1'b0);
        chk(b_addr_bad == 0 && exp_row == 3, "R5 row resumes after CBR", exp_row, 3);

        // R8 pending refreshes: directed saturation then random waits
        for (int t = 0; t < 6; t++) begin
            m = (t == 0) ? 5 : (t == 1) ? 0 : int'($urandom_range(0, 5));
            mode_cbr = 1'($urandom_range(0, 1));
            gnt = 1'b0;
            wait_req();
            n = 0;
            for (int i = 0; i < m * REFI; i++) begin
                @(negedge clk);
                if (!req || drive) n++;
            end
            chk(n == 0, "R8 request held without driving", n, 0);
            gnt = 1'b1;
            burst(mode_cbr, 1'b0);
            chk(b_pulses == exp_burst(m), "R8 burst length", b_pulses, exp_burst(m));
            chk(b_cas_bad == 0 && b_addr_bad == 0 && b_drv_bad == 0, "R10 burst pin ownership",
                b_cas_bad + b_addr_bad + b_drv_bad, 0);
        end

        // R9 inactivity and re-initialization
        mode_cbr = 1'b0;
        gnt = 1'b0;
        n = 0;
        for (int k = 0; k < 10; k++) begin
            ext = 1'b1;
            @(negedge clk);
            ext = 1'b0;
            for (int i = 0; i < 49; i++) begin
                @(negedge clk);
                if (!ready) n++;
            end
        end
        chk(n == 0, "R9 outside activity keeps ready", n, 0);
        ext = 1'b1;
        @(negedge clk);
        ext = 1'b0;
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            n++;
            if (!ready) break;
        end
        chk(n == IDLE, "R9 inactivity limit", n, IDLE);
        chk(req && !drive, "R9 request after ready drop", {req, drive}, 2'b10);
        m = cyc;
        gnt = 1'b1;
        burst(1'b0, 1'b1);
        chk(b_first - m == 1, "R9 no pause before re-init", b_first - m, 1);
        chk(b_pulses == INITN && ready, "R9 re-init cycle count", b_pulses, INITN);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule